// File: doc/BRIEF.md
# Serial Character Receiver with Sticky Error Flags

This block takes an idle-high asynchronous serial line and assembles 8-bit characters from it. Each frame has a low start bit, eight data bits sent least significant bit first, an optional parity bit and one high stop bit. A bit-period length in clock cycles sets the timing. When the stop bit has been sampled, the character is copied into a holding register and a ready flag is raised. The host consumes the character by pulsing a read strobe.

Two error flags sit beside the ready flag. Overrun reports that a character arrived while the previous one was still unread. Parity error reports a mismatch between the received parity bit and the bit the configured mode expects. Both flags are sticky. They survive reads and later good characters, and only a dedicated clear-status pulse returns them to zero.

Top module: `serial_rx_status`

## Requirements
- R1: After reset, `rx_data` is 0 and `rx_ready`, `overrun` and `parity_err` are all 0.
- R2: The line passes through a two-flop synchronizer. A falling edge starts a start-bit check half a bit period later. If the line is high at that sample, the receiver returns to idle and leaves the data and all flags unchanged.
- R3: After a confirmed start bit, each later bit is sampled one full bit period after the previous sample. The data bits are assembled LSB first. When the stop bit is sampled, the byte is loaded into `rx_data` and `rx_ready` is set.
- R4: A `rd_strobe` pulse clears `rx_ready` when no character completes in that same cycle.
- R5: If a character completes while `rx_ready` is 1 and no read happens in that cycle, `overrun` is set. The new byte replaces `rx_data` and `rx_ready` stays 1.
- R6: `overrun` is cleared only by `clr_status`. A read leaves it set.
- R7: `par_mode` selects the parity check. 000 expects the XOR of the data bits (even). 001 expects its inverse (odd). 010 expects 0 and 011 expects 1. On a mismatch, `parity_err` rises in the same cycle as `rx_ready`.
- R8: When `par_mode[2]` is 1, the frame carries no parity bit (start, 8 data bits, stop) and `parity_err` is never set.
- R9: `parity_err` stays set through reads and later good characters. Only `clr_status` clears it.
- R10: A read and a character completion in the same cycle leave `rx_ready` at 1, load the new byte, and do not set `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial line, idle high |
| bit_cycles | input | CNT_W | Clock cycles per bit period (at least 4) |
| par_mode | input | 3 | Parity mode, latched at the start of each frame |
| rd_strobe | input | 1 | Host has read the holding register |
| clr_status | input | 1 | Clear overrun and parity error |
| rx_data | output | 8 | Holding register |
| rx_ready | output | 1 | Unread character present |
| overrun | output | 1 | Sticky overrun flag |
| parity_err | output | 1 | Sticky parity error flag |

## Verification
The host read and the completion of a new character can fall in the same clock cycle. The bench provokes this by first leaving one character unread. It then raises `rd_strobe` for exactly the cycle in which the following stop bit is sampled. That cycle is counted from the falling edge through the synchronizer and the half-bit and full-bit waits. Afterwards `rx_ready` must still read 1, `rx_data` must hold the second byte, and `overrun` must stay 0. An off-by-one in the read priority or in the sample timing shows up as a cleared ready flag or a spurious overrun.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP
  } rx_state_e;

  // a parity bit is present in the frame unless the top mode bit is set
  function automatic logic par_used(input logic [2:0] mode);
    return !mode[2];
  endfunction

  // value the parity bit must carry for a given data byte and mode
  function automatic logic par_expect(input logic [7:0] data, input logic [2:0] mode);
    logic r;
    case (mode[1:0])
      2'b00:   r = ^data;
      2'b01:   r = ~^data;
      2'b10:   r = 1'b0;
      default: r = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/srx_frame.sv
module srx_frame
  import srx_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line,
  input  logic [CNT_W-1:0]  bit_cycles,
  input  logic [2:0]        par_mode,
  output logic              char_done,
  output logic [DATA_W-1:0] char_data,
  output logic              char_par_bad
);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] shreg;
  logic [2:0]        mode_q;
  logic              prev;
  logic              bad_q;
  logic              sample_now;

  assign sample_now = (state != S_IDLE) && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      idx    <= '0;
      shreg  <= '0;
      mode_q <= '0;
      prev   <= 1'b1;
      bad_q  <= 1'b0;
    end else begin
      prev <= line;
      if (state == S_IDLE) begin
        if (prev && !line) begin
          state  <= S_START;
          cnt    <= (bit_cycles >> 1) - CNT_W'(1);
          mode_q <= par_mode;
          bad_q  <= 1'b0;
        end
      end else if (!sample_now) begin
        cnt <= cnt - CNT_W'(1);
      end else begin
        cnt <= bit_cycles - CNT_W'(1);
        unique case (state)
          S_START: begin
            if (line) state <= S_IDLE;
            else begin
              state <= S_DATA;
              idx   <= '0;
            end
          end
          S_DATA: begin
            shreg <= {line, shreg[DATA_W-1:1]};
            if (idx == LAST_IDX) state <= par_used(mode_q) ? S_PAR : S_STOP;
            else                 idx   <= idx + IDX_W'(1);
          end
          S_PAR: begin
            bad_q <= (line != par_expect(shreg, mode_q));
            state <= S_STOP;
          end
          S_STOP:  state <= S_IDLE;
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assign char_done    = sample_now && (state == S_STOP);
  assign char_data    = shreg;
  assign char_par_bad = bad_q;

  // R2
  glitch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_START && sample_now && line) |=> (state == S_IDLE));

  // R8
  no_par_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PAR) |-> par_used(mode_q));

  // R8
  no_par_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && !par_used(mode_q)) |-> !char_par_bad);
endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status
  import srx_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxd,
  input  logic [CNT_W-1:0] bit_cycles,
  input  logic [2:0]       par_mode,
  input  logic             rd_strobe,
  input  logic             clr_status,
  output logic [7:0]       rx_data,
  output logic             rx_ready,
  output logic             overrun,
  output logic             parity_err
);
  localparam int DATA_W = 8;

  logic              line_s;
  logic              char_done;
  logic [DATA_W-1:0] char_data;
  logic              char_par_bad;
  logic              ovr_event;

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(line_s)
  );

  srx_frame #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .line(line_s),
    .bit_cycles(bit_cycles), .par_mode(par_mode),
    .char_done(char_done), .char_data(char_data), .char_par_bad(char_par_bad)
  );

  assign ovr_event = char_done && rx_ready && !rd_strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data    <= '0;
      rx_ready   <= 1'b0;
      overrun    <= 1'b0;
      parity_err <= 1'b0;
    end else begin
      if (char_done) begin
        rx_data  <= char_data;
        rx_ready <= 1'b1;
      end else if (rd_strobe) begin
        rx_ready <= 1'b0;
      end
      overrun    <= (overrun && !clr_status) || ovr_event;
      parity_err <= (parity_err && !clr_status) || (char_done && char_par_bad);
    end
  end

  // R3
  ready_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    char_done |=> rx_ready);

  // R4
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !char_done) |=> !rx_ready);

  // R5
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && rx_ready && !rd_strobe) |=> (overrun && rx_ready));

  // R6
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !clr_status) |=> overrun);

  // R9
  pare_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (parity_err && !clr_status) |=> parity_err);

  // R10
  same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && rd_strobe && !overrun) |=> (rx_ready && !overrun));
endmodule

// File: tb/serial_rx_status_test.sv
module serial_rx_status_test;
  localparam int CLK_PERIOD = 10;
  localparam int BITC       = 8;
  localparam int NVEC       = 10;

  // vector: {data[11:4], mode[3:1], flip_parity[0]}
  localparam logic [11:0] VEC [NVEC] = '{
    {8'hA5, 3'd0, 1'b0}, {8'h3C, 3'd1, 1'b0}, {8'h01, 3'd0, 1'b1},
    {8'h80, 3'd1, 1'b1}, {8'h5A, 3'd2, 1'b0}, {8'h5A, 3'd2, 1'b1},
    {8'hFF, 3'd3, 1'b0}, {8'h00, 3'd3, 1'b1}, {8'h96, 3'd4, 1'b0},
    {8'h69, 3'd7, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rxd = 1'b1;
  logic [15:0] bit_cycles = 16'(BITC);
  logic [2:0]  par_mode = 3'd0;
  logic        rd_strobe = 1'b0;
  logic        clr_status = 1'b0;
  logic [7:0]  rx_data;
  logic        rx_ready, overrun, parity_err;

  int checks = 0;
  int errors = 0;

  serial_rx_status uut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .bit_cycles(bit_cycles),
    .par_mode(par_mode), .rd_strobe(rd_strobe), .clr_status(clr_status),
    .rx_data(rx_data), .rx_ready(rx_ready), .overrun(overrun),
    .parity_err(parity_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    rxd = b;
    idle(BITC);
  endtask

  task automatic pulse_read();
    rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0;
  endtask

  task automatic pulse_clr();
    clr_status = 1'b1; @(negedge clk); clr_status = 1'b0;
  endtask

  // expected parity bit, computed by counting ones
  function automatic logic want_par(input logic [7:0] d, input logic [2:0] m);
    int ones = 0;
    for (int i = 0; i < 8; i++) if (d[i]) ones++;
    if (m == 3'd0) return (ones % 2) == 1;
    if (m == 3'd1) return (ones % 2) == 0;
    if (m == 3'd2) return 1'b0;
    return 1'b1;
  endfunction

  task automatic send_frame(input logic [7:0] d, input logic [2:0] m,
                            input logic flip, input logic rd_at_stop);
    par_mode = m;
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    if (!m[2]) send_bit(want_par(d, m) ^ flip);
    if (rd_at_stop) begin
      rxd = 1'b1;
      idle(6);
      rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
      @(negedge clk);
    end else begin
      send_bit(1'b1);
    end
    idle(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    check("R1", "rx_data", rx_data, 0);
    check("R1", "rx_ready", rx_ready, 0);
    check("R1", "overrun", overrun, 0);
    check("R1", "parity_err", parity_err, 0);

    // R3 R7 R8 vector walk
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] d;
      logic [2:0] m;
      logic       f;
      d = VEC[v][11:4]; m = VEC[v][3:1]; f = VEC[v][0];
      pulse_clr();
      send_frame(d, m, f, 1'b0);
      check("R3", "rx_data", rx_data, d);
      check("R3", "rx_ready", rx_ready, 1);
      check(m[2] ? "R8" : "R7", "parity_err", parity_err, int'(f && !m[2]));
      check("R5", "overrun", overrun, 0);
      pulse_read();
      check("R4", "rx_ready after read", rx_ready, 0);
      check("R9", "parity_err after read", parity_err, int'(f && !m[2]));
    end

    // R5 R6 overrun
    pulse_clr();
    send_frame(8'h11, 3'd4, 1'b0, 1'b0);
    send_frame(8'h22, 3'd4, 1'b0, 1'b0);
    check("R5", "overrun", overrun, 1);
    check("R5", "rx_data", rx_data, 8'h22);
    check("R5", "rx_ready", rx_ready, 1);
    pulse_read();
    check("R6", "overrun after read", overrun, 1);
    pulse_clr();
    check("R6", "overrun after clear", overrun, 0);

    // R9 parity error sticky across a good character
    send_frame(8'h33, 3'd0, 1'b1, 1'b0);
    pulse_read();
    send_frame(8'h44, 3'd0, 1'b0, 1'b0);
    check("R9", "parity_err kept", parity_err, 1);
    pulse_read();
    pulse_clr();
    check("R9", "parity_err cleared", parity_err, 0);

    // R10 read and completion in the same cycle
    send_frame(8'hC3, 3'd4, 1'b0, 1'b0);
    check("R10", "first ready", rx_ready, 1);
    send_frame(8'h7E, 3'd4, 1'b0, 1'b1);
    check("R10", "rx_ready", rx_ready, 1);
    check("R10", "rx_data", rx_data, 8'h7E);
    check("R10", "overrun", overrun, 0);
    pulse_read();

    // R2 short low pulse is rejected
    rxd = 1'b0; idle(2); rxd = 1'b1; idle(20);
    check("R2", "rx_ready after glitch", rx_ready, 0);
    check("R2", "rx_data after glitch", rx_data, 8'h7E);
    check("R2", "overrun after glitch", overrun, 0);
    check("R2", "parity_err after glitch", parity_err, 0);
    send_frame(8'h5C, 3'd1, 1'b0, 1'b0);
    check("R2", "frame after glitch", rx_data, 8'h5C);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule